// File: doc/BRIEF.md
# Watchdog Timer With Keyed Run Control

This block is a memory-mapped watchdog counter that advances on a slow timebase. The slow timebase arrives as a single-cycle `tick` strobe in the bus clock domain. Software reaches it through a plain word-addressed register port: an address, write data, a write strobe and a combinational read-data path. A 32-bit counter counts upward from a software-chosen reload value. The counter moves on every tick, or on every 2^N ticks when the divider is switched on. If the counter rolls over past its all-ones value, the block drives a fixed-length reset pulse and starts again from the reload value.

Writes to the control, reload, trigger and run-key registers do not take effect at once. Each one is held in a posting slot for a fixed number of slow ticks, which stands in for the crossing into the slow clock domain, and a status register shows which slots are still busy. Software keeps the watchdog alive by writing a trigger value that differs from the previous one. It starts or stops the counter only with a two-word key pair, so a single stray write cannot switch the watchdog off.

Top module: `wdt_unit`

## Requirements
- R1: After reset the counter is stopped and reads 0. The control, reload and last-trigger registers read 0, the pending status reads 0 and `wdt_rst` is low. Address 0 returns the revision parameter in bits 7:0.
- R2: Word addresses are 1 control, 3 reload, 4 trigger and 6 run key. A write to one of these sets its pending flag in the status register at address 5. The flag positions are bit 0 control, bit 2 reload, bit 3 trigger and bit 4 run key. The flag is visible from the next cycle and clears on the clock edge that accepts the fourth `tick` after the write. The new value takes effect on that same edge, and until then a read returns the old value.
- R3: A write to a register whose pending flag is set is discarded. The value already posted is the one that takes effect.
- R4: A run-key commit of 0x0000BBBB followed directly by a run-key commit of 0x00004444 starts the counter. Full 32-bit equality is required.
- R5: A run-key commit of 0x0000AAAA followed directly by a run-key commit of 0x00005555 stops the counter. A commit of any other value, or of a second key word without its first word directly before it, leaves the run state unchanged and cancels a half-entered pair.
- R6: While running, the counter advances by 1 per step. With control bit 5 clear, every tick is a step. With bit 5 set, every 2^P ticks is a step, where P is control bits 4:2. While stopped, the counter holds its value.
- R7: A committed trigger value that differs from the last committed trigger value loads the counter from the reload register, whether running or stopped. The last trigger value is 0 after reset. A committed trigger equal to the last one leaves the counter alone. Address 4 reads the last committed trigger value.
- R8: A step taken at counter value 0xFFFFFFFF loads the counter from the reload register and drives `wdt_rst` high for exactly `RST_CYC` (default 8) clock cycles.
- R9: Address 2 reads the live counter, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle slow timebase strobe, synchronous to `clk` |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DW | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | DW | Combinational read data for `addr` |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The assertions take for granted that `tick` is a one-cycle strobe aligned to `clk`. They also assume that software waits for a slot's pending flag to clear before depending on its value, so that a trigger reload and a rollover seen in one cycle are ordered in the way the properties state. The stimulus raises `tick` for exactly one cycle out of every three and changes the bus inputs just after the falling edge. It polls the status register until it reads zero before each dependent step, and it writes into a busy slot only once, on purpose, to show that the write is discarded. Key pairs are sent both in order and broken up by foreign words, so that the run state is exercised for both kinds of key sequence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // posting slots, in slot-index order
   localparam int NSLOT = 4;
   localparam int S_CTRL = 0;
   localparam int S_LOAD = 1;
   localparam int S_TRIG = 2;
   localparam int S_KEY  = 3;

   // word addresses (3 bits of decode)
   localparam logic [2:0] A_REV   = 3'd0;
   localparam logic [2:0] A_CTRL  = 3'd1;
   localparam logic [2:0] A_COUNT = 3'd2;
   localparam logic [2:0] A_LOAD  = 3'd3;
   localparam logic [2:0] A_TRIG  = 3'd4;
   localparam logic [2:0] A_PEND  = 3'd5;
   localparam logic [2:0] A_KEY   = 3'd6;

   // control field layout
   localparam int CTRL_EN_BIT  = 5;
   localparam int CTRL_PTV_LSB = 2;
   localparam int PTV_W        = 3;
   localparam int PSTAT_W      = 5;

   // run-key words
   localparam logic [15:0] KEY_ON1  = 16'hBBBB;
   localparam logic [15:0] KEY_ON2  = 16'h4444;
   localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
   localparam logic [15:0] KEY_OFF2 = 16'h5555;

   typedef enum logic [1:0] {K_IDLE, K_ARM_ON, K_ARM_OFF} key_st_e;

   function automatic logic [2:0] slot_addr(input int s);
      case (s)
         S_CTRL:  return A_CTRL;
         S_LOAD:  return A_LOAD;
         S_TRIG:  return A_TRIG;
         default: return A_KEY;
      endcase
   endfunction

   function automatic int slot_pbit(input int s);
      case (s)
         S_CTRL:  return 0;
         S_LOAD:  return 2;
         S_TRIG:  return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
   parameter int DW  = 32,
   parameter int LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          pend,
   output logic          commit,
   output logic [DW-1:0] cdata
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   if (LAT < 1) begin : g_bad_lat
      $error("wdt_post_slot: LAT must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          last_tick;

   assign last_tick = (cnt_q == CW'(LAT - 1));
   assign commit    = pend & tick & last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         cnt_q <= '0;
         cdata <= '0;
      end else if (commit) begin
         pend <= 1'b0;
      end else if (pend && tick) begin
         cnt_q <= cnt_q + CW'(1);
      end else if (wr && !pend) begin
         pend  <= 1'b1;
         cnt_q <= '0;
         cdata <= wdata;
      end
   end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PTV_W   = 3,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clr,
   input  logic             en,
   input  logic [PTV_W-1:0] ptv,
   output logic             step
);
   localparam int DIV_W = ((1 << PTV_W) - 1 > 0) ? (1 << PTV_W) - 1 : 1;

   if (PTV_W < 1) begin : g_bad_ptv
      $error("wdt_prescaler: PTV_W must be at least 1");
   end

   if (HAS_DIV) begin : g_div
      logic [DIV_W-1:0] div_q;
      logic [DIV_W:0]   one_sh;
      logic [DIV_W-1:0] lim;
      logic             wrap;

      assign one_sh = (DIV_W + 1)'(1) << ptv;
      assign lim    = DIV_W'(one_sh - (DIV_W + 1)'(1));
      assign wrap   = (div_q == lim);
      assign step   = run & tick & (~en | wrap);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          div_q <= '0;
         else if (!run || clr) div_q <= '0;
         else if (tick && en) div_q <= wrap ? '0 : div_q + DIV_W'(1);
      end
   end else begin : g_nodiv
      assign step = run & tick;
   end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdt_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic [DW-1:0] key,
   output logic          run
);
   key_st_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= K_IDLE;
         run  <= 1'b0;
      end else if (commit) begin
         if (key == DW'(KEY_ON1)) begin
            st_q <= K_ARM_ON;
         end else if (key == DW'(KEY_OFF1)) begin
            st_q <= K_ARM_OFF;
         end else begin
            st_q <= K_IDLE;
            if (st_q == K_ARM_ON && key == DW'(KEY_ON2))   run <= 1'b1;
            if (st_q == K_ARM_OFF && key == DW'(KEY_OFF2)) run <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
   import wdt_pkg::*;
#(
   parameter int         DW            = 32,
   parameter int         ADDR_W        = 3,
   parameter int         SYNC_LAT      = 4,
   parameter int         RST_CYC       = 8,
   parameter logic [7:0] REV           = 8'h21,
   parameter bit         HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              we,
   output logic [DW-1:0]     rdata,
   output logic              wdt_rst
);
   localparam int RC_W = $clog2(RST_CYC + 1);

   if (DW < 16)     begin : g_bad_dw  $error("wdt_unit: DW must hold the 16-bit key words"); end
   if (ADDR_W < 3)  begin : g_bad_aw  $error("wdt_unit: ADDR_W must be at least 3"); end
   if (RST_CYC < 1) begin : g_bad_rc  $error("wdt_unit: RST_CYC must be at least 1"); end

   // ---------------- posted write slots ----------------
   logic          pend_v   [NSLOT];
   logic          commit_v [NSLOT];
   logic [DW-1:0] cdata_v  [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic sel;
      assign sel = we && (addr == ADDR_W'(slot_addr(s)));
      wdt_post_slot #(.DW(DW), .LAT(SYNC_LAT)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .wr     (sel),
         .wdata  (wdata),
         .pend   (pend_v[s]),
         .commit (commit_v[s]),
         .cdata  (cdata_v[s])
      );
   end

   logic [PSTAT_W-1:0] pstat;
   always_comb begin
      pstat = '0;
      for (int s = 0; s < NSLOT; s++) pstat[slot_pbit(s)] = pend_v[s];
   end

   // ---------------- committed registers ----------------
   logic             pre_en_q;
   logic [PTV_W-1:0] ptv_q;
   logic [DW-1:0]    load_q;
   logic [DW-1:0]    trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_en_q <= 1'b0;
         ptv_q    <= '0;
         load_q   <= '0;
         trig_q   <= '0;
      end else begin
         if (commit_v[S_CTRL]) begin
            pre_en_q <= cdata_v[S_CTRL][CTRL_EN_BIT];
            ptv_q    <= cdata_v[S_CTRL][CTRL_PTV_LSB +: PTV_W];
         end
         if (commit_v[S_LOAD]) load_q <= cdata_v[S_LOAD];
         if (commit_v[S_TRIG]) trig_q <= cdata_v[S_TRIG];
      end
   end

   // ---------------- run control and timebase ----------------
   logic run_q;
   logic step;

   wdt_keyseq #(.DW(DW)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit_v[S_KEY]),
      .key    (cdata_v[S_KEY]),
      .run    (run_q)
   );

   wdt_prescaler #(.PTV_W(PTV_W), .HAS_DIV(HAS_PRESCALER)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (run_q),
      .clr   (commit_v[S_CTRL]),
      .en    (pre_en_q),
      .ptv   (ptv_q),
      .step  (step)
   );

   // ---------------- counter and reset pulse ----------------
   logic [DW-1:0]   cnt_q;
   logic [RC_W-1:0] rc_q;
   logic            trig_reload;
   logic            ovf;

   assign trig_reload = commit_v[S_TRIG] && (cdata_v[S_TRIG] != trig_q);
   assign ovf         = step && !trig_reload && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (trig_reload || ovf) cnt_q <= load_q;
      else if (step)             cnt_q <= cnt_q + DW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rc_q <= '0;
      else if (ovf)        rc_q <= RC_W'(RST_CYC);
      else if (rc_q != '0) rc_q <= rc_q - RC_W'(1);
   end

   assign wdt_rst = (rc_q != '0);

   // ---------------- read path ----------------
   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_REV):   rdata[7:0] = REV;
         ADDR_W'(A_CTRL): begin
            rdata[CTRL_EN_BIT]               = pre_en_q;
            rdata[CTRL_PTV_LSB +: PTV_W]     = ptv_q;
         end
         ADDR_W'(A_COUNT): rdata = cnt_q;
         ADDR_W'(A_LOAD):  rdata = load_q;
         ADDR_W'(A_TRIG):  rdata = trig_q;
         ADDR_W'(A_PEND):  rdata[PSTAT_W-1:0] = pstat;
         default:          rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_unit_chk.sv
module wdt_unit_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          run,
   input logic          step,
   input logic          trig_reload,
   input logic          ovf,
   input logic [DW-1:0] cnt,
   input logic [DW-1:0] load,
   input logic [4:0]    pstat,
   input logic          key_commit,
   input logic          wdt_rst
);
   AST_PEND_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ((~pstat & $past(pstat)) == 5'd0));                       // R2

   AST_RUN_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      !key_commit |=> $stable(run));                                       // R4

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !trig_reload) |=> $stable(cnt));                            // R6

   AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !trig_reload && !(&cnt)) |=> (cnt == $past(cnt) + DW'(1))); // R6

   AST_RELOAD_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      trig_reload |=> (cnt == $past(load)));                               // R7

   AST_OVF_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (wdt_rst && cnt == $past(load)));                            // R8

   AST_RST_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> $past(ovf));                                      // R8
endmodule

bind wdt_unit wdt_unit_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .run         (run_q),
   .step        (step),
   .trig_reload (trig_reload),
   .ovf         (ovf),
   .cnt         (cnt_q),
   .load        (load_q),
   .pstat       (pstat),
   .key_commit  (commit_v[3]),
   .wdt_rst     (wdt_rst)
);

// File: tb/tb_wdt_unit.sv
module tb_wdt_unit;
   localparam int LAT  = 4;
   localparam int RSTC = 8;
   localparam int TP   = 3;
   localparam logic [7:0] REVV = 8'h21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        wdt_rst;

   int n_tests = 0;
   int n_fail  = 0;
   bit done = 0;
   bit cmp_on = 0;
   bit tick_on = 0;

   always #4 clk = ~clk;

   wdt_unit #(.RST_CYC(RSTC), .SYNC_LAT(LAT), .REV(REVV)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
      .wdata(wdata), .we(we), .rdata(rdata), .wdt_rst(wdt_rst));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int unsigned slot_a [4] = '{1, 3, 4, 6};
   int unsigned m_cnt, m_load, m_trig;
   int unsigned m_pd [4];
   bit          m_pend [4];
   int          m_pc [4];
   bit          m_en, m_run;
   int          m_ptv, m_div, m_arm, m_rst;
   bit          cm [4];
   int unsigned cd [4];
   bit          stp, rl, ov;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_load = 0; m_trig = 0; m_en = 0; m_run = 0;
         m_ptv = 0; m_div = 0; m_arm = 0; m_rst = 0;
         for (int i = 0; i < 4; i++) begin m_pd[i] = 0; m_pend[i] = 0; m_pc[i] = 0; end
      end else begin
         for (int i = 0; i < 4; i++) begin
            cm[i] = m_pend[i] && tick && (m_pc[i] == LAT - 1);
            cd[i] = m_pd[i];
         end
         stp = 0;
         if (m_run && tick) stp = !m_en || (m_div == (1 << m_ptv) - 1);
         if (!m_run || cm[0]) m_div = 0;
         else if (tick && m_en) m_div = stp ? 0 : m_div + 1;
         rl = cm[2] && (cd[2] != m_trig);
         ov = !rl && stp && (m_cnt == 32'hFFFF_FFFF);
         if (rl || ov) m_cnt = m_load;
         else if (stp) m_cnt = m_cnt + 1;
         if (ov) m_rst = RSTC;
         else if (m_rst > 0) m_rst--;
         if (cm[0]) begin m_en = cd[0][5]; m_ptv = int'((cd[0] >> 2) & 7); end
         if (cm[1]) m_load = cd[1];
         if (cm[2]) m_trig = cd[2];
         if (cm[3]) begin
            if (cd[3] == 32'hBBBB) m_arm = 1;
            else if (cd[3] == 32'hAAAA) m_arm = 2;
            else begin
               if (m_arm == 1 && cd[3] == 32'h4444) m_run = 1;
               if (m_arm == 2 && cd[3] == 32'h5555) m_run = 0;
               m_arm = 0;
            end
         end
         for (int i = 0; i < 4; i++) begin
            if (cm[i]) m_pend[i] = 0;
            else if (m_pend[i] && tick) m_pc[i]++;
            else if (we && addr == slot_a[i] && !m_pend[i]) begin
               m_pend[i] = 1; m_pc[i] = 0; m_pd[i] = wdata;
            end
         end
      end
   end

   function automatic int unsigned exp_rd(input int a);
      case (a)
         0: return {24'd0, REVV};
         1: return (int'(m_en) << 5) | (m_ptv << 2);
         2: return m_cnt;
         3: return m_load;
         4: return m_trig;
         5: return (int'(m_pend[0])) | (int'(m_pend[1]) << 2) |
                   (int'(m_pend[2]) << 3) | (int'(m_pend[3]) << 4);
         default: return 0;
      endcase
   endfunction

   // compare against the model on every clock, away from the rising edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R9 read path", rdata, exp_rd(int'(addr)));
         chk("R8 reset pulse", wdt_rst, (m_rst > 0));
      end
   end

   // slow timebase strobe
   initial begin
      int tc = 0;
      forever begin
         @(negedge clk); #1;
         tc++;
         tick = tick_on && (tc % TP == 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); #1; addr = a; wdata = d; we = 1'b1;
      @(negedge clk); #1; we = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk); #1; addr = a;
      @(negedge clk); v = rdata;
   endtask

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk); #1; addr = 3'd5;
      do begin
         @(negedge clk);
         guard++;
      end while (rdata[4:0] != 5'd0 && guard < 200);
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         do @(negedge clk); while (!tick);
      end
   endtask

   task automatic key_wr(input logic [31:0] d);
      bus_wr(3'd6, d);
      wait_idle();
   endtask

   task automatic diff_over(input int n, output longint dv);
      logic [31:0] c0;
      @(negedge clk); #1; addr = 3'd2;
      wait_ticks(1); c0 = rdata;
      wait_ticks(n);
      dv = longint'(rdata) - longint'(c0);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] v;
      longint      dv;
      int          w, g;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1;

      // R1: reset state
      bus_rd(3'd0, v); chk("R1 revision", v[7:0], REVV);
      bus_rd(3'd1, v); chk("R1 control", v, 0);
      bus_rd(3'd2, v); chk("R1 counter", v, 0);
      bus_rd(3'd3, v); chk("R1 reload", v, 0);
      bus_rd(3'd5, v); chk("R1 pending", v, 0);
      chk("R1 reset out", wdt_rst, 0);
      tick_on = 1;

      // R2 / R3: posted reload write, second write discarded
      bus_wr(3'd3, 32'h100);
      bus_rd(3'd5, v); chk("R2 reload pending bit 2", v, 32'h4);
      bus_rd(3'd3, v); chk("R2 old reload still visible", v, 0);
      bus_wr(3'd3, 32'h200);
      wait_idle();
      bus_rd(3'd3, v); chk("R3 busy write discarded", v, 32'h100);
      bus_rd(3'd6, v); chk("R9 run key reads zero", v, 0);

      // R7: trigger reload while stopped
      bus_wr(3'd4, 32'h5A); wait_idle();
      bus_rd(3'd2, v); chk("R7 reload while stopped", v, 32'h100);
      bus_rd(3'd4, v); chk("R7 last trigger readback", v, 32'h5A);

      // R4 broken: second word first, then first word alone -> stays stopped
      key_wr(32'h4444); key_wr(32'hBBBB); key_wr(32'h1234); key_wr(32'h4444);
      diff_over(6, dv); chk("R4 broken start pair ignored", dv, 0);

      // R4: proper start, divider off -> one step per tick
      key_wr(32'hBBBB); key_wr(32'h4444);
      diff_over(10, dv); chk("R4 R6 running, one step per tick", dv, 10);

      // R7: same trigger value does not reload
      bus_wr(3'd4, 32'h5A); wait_idle();
      bus_rd(3'd2, v); chk("R7 equal trigger no reload", (v > 32'h108), 1);
      bus_wr(3'd4, 32'h5B); wait_idle();
      bus_rd(3'd2, v); chk("R7 new trigger reloads", (v <= 32'h101 && v >= 32'h100), 1);

      // R6: divider on, P = 2 -> one step per 4 ticks
      bus_wr(3'd1, 32'h28); wait_idle();
      bus_rd(3'd1, v); chk("R2 control committed", v, 32'h28);
      diff_over(32, dv); chk("R6 divide by 4", dv, 8);

      // R5: stop pair broken by a foreign word -> still running
      key_wr(32'hAAAA); key_wr(32'h1111); key_wr(32'h5555);
      diff_over(16, dv); chk("R5 broken stop pair ignored", dv, 4);

      // R5: proper stop
      key_wr(32'hAAAA); key_wr(32'h5555);
      diff_over(12, dv); chk("R5 stopped counter holds", dv, 0);

      // R8: rollover
      bus_wr(3'd1, 32'h0); wait_idle();
      bus_wr(3'd3, 32'hFFFF_FFF0); wait_idle();
      bus_wr(3'd4, 32'h77); wait_idle();
      key_wr(32'hBBBB); key_wr(32'h4444);
      g = 0;
      do begin @(negedge clk); g++; end while (!wdt_rst && g < 1000);
      chk("R8 reset pulse seen", wdt_rst, 1);
      w = 0;
      while (wdt_rst && w < 100) begin w++; @(negedge clk); end
      chk("R8 pulse length", w, RSTC);
      bus_rd(3'd2, v); chk("R8 counter restarted from reload", (v >= 32'hFFFF_FFF0), 1);
      key_wr(32'hAAAA); key_wr(32'h5555);

      repeat (4) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule